// File: doc/BRIEF.md
# Ballast Startup and Fault Sequencer

This block is the control sequencer of a half-bridge lamp ballast. It takes the digital outputs of the analog comparators (supply above the upper and lower undervoltage levels, chip enable, current sense above the ignition level and above the over-current level, and open-load sense above its level) and walks the ballast through four phases. These are idle, timed ignition at the high frequency, run at the low frequency with burst dimming, and a latched fault. The supply and enable hysteresis lives in the comparators. The block only sees their two supply bits and the one enable bit.

A single ramp counter serves two purposes. During ignition it times the ignition window. During run it becomes the fast sawtooth that the dimming comparator uses. A single delay counter is shared between the open-load shutdown delay and the over-current duty limiter. The PWM stage reads that counter as its duty reduction. When the counter reaches its terminal count, the ballast latches into fault. The fault can be cleared only by taking the supply below the lower undervoltage level.

Top module: `ballast_seq`

## Requirements
- R1: After reset every output is 0 (ramp and delay count included). The block stays idle until a clock edge sees the upper supply bit and the enable bit both high.
- R2: The edge that leaves idle enters ignition. From then on `ign_mode` (high frequency select) and `osc_en` are 1, `run_mode` and `fault` are 0, and `ramp` starts from 0.
- R3: During ignition `ramp` rises by 1 per cycle. The window lasts exactly IGN_TOP+1 cycles. The ignition current sense is consulted only on the cycle where `ramp` equals IGN_TOP.
- R4: At the end of the window, a high ignition current sense moves the block to run (`run_mode`=1, `ign_mode`=0, `ramp` back to 0). A low one moves it to fault.
- R5: In run, `ramp` advances by RUN_STEP per cycle modulo 2^RAMP_W. `burst_en` is 1 in run except in cycles where open-load sense was high at the edge.
- R6: In run, each edge with open-load sense high adds 1 to `dly_cnt`. The first edge after it goes low, with over-current also low, clears `dly_cnt` to 0.
- R7: In run, each edge with over-current high adds 1 to `dly_cnt`. When over-current goes low and open-load sense was low on the previous edge, `dly_cnt` holds its value. When both senses are high, the count still grows by only 1 per cycle.
- R8: The edge on which `dly_cnt` reaches DLY_MAX in run enters fault. There `fault`=1, and `osc_en`, `ign_mode`, `run_mode` and `burst_en` are 0. `dly_cnt` holds DLY_MAX while the fault lasts.
- R9: Fault ignores enable and the upper supply bit. It is left only on an edge where the lower supply bit is low, which returns the block to idle. A restart then needs R1's condition again.
- R10: In ignition or run, an edge where the lower supply bit or enable is low returns to idle. This takes priority over the end of the ignition window and over the delay terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_above_hi | input | 1 | Supply above upper undervoltage level |
| vcc_above_lo | input | 1 | Supply above lower undervoltage level |
| enable | input | 1 | Enable comparator output |
| cs_ign_hi | input | 1 | Current sense above ignition level |
| cs_oc_hi | input | 1 | Current sense above over-current level |
| sd_open_hi | input | 1 | Open-load sense above its level |
| ign_mode | output | 1 | Ignition phase; selects the high frequency |
| run_mode | output | 1 | Run phase; selects the low frequency |
| osc_en | output | 1 | Oscillator and gate drive enable |
| burst_en | output | 1 | Burst dimming allowed |
| fault | output | 1 | Latched fault |
| dly_cnt | output | DLY_W | Shared delay count, duty reduction for PWM |
| ramp | output | RAMP_W | Ignition timer / burst dimming sawtooth |

## Verification
Two pairs of functions can land on the same edge. In the first pair, the open-load delay and the over-current limiter share one counter. The bench raises both senses together and checks that the count grows by one per cycle, not two. It then drops open-load while over-current stays high and expects counting to continue. Finally it drops both at once and expects a clear, because the open-load rule wins. In the second pair, a supply or enable loss coincides with the end of the ignition window or with the delay terminal count. These are provoked on exactly that edge, and idle rather than run or fault is the expected result. A seeded random phase mixes both senses in run and compares count, fault and burst enable against a bench model each cycle.

// File: rtl/ballast_seq_pkg.sv
package ballast_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_IGN   = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } bal_state_t;
endpackage

// File: rtl/bal_ramp_gen.sv
module bal_ramp_gen #(
  parameter int RAMP_W   = 8,
  parameter int IGN_TOP  = 200,
  parameter int RUN_STEP = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_ign,
  input  logic              in_run,
  output logic [RAMP_W-1:0] ramp,
  output logic              ign_done
);
  localparam logic [RAMP_W-1:0] TOP_V  = RAMP_W'(IGN_TOP);
  localparam logic [RAMP_W-1:0] STEP_V = RAMP_W'(RUN_STEP);

  assign ign_done = in_ign && (ramp == TOP_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp <= '0;
    end else if (in_ign) begin
      ramp <= ign_done ? '0 : ramp + 1'b1;
    end else if (in_run) begin
      ramp <= ramp + STEP_V;
    end else begin
      ramp <= '0;
    end
  end

  // R3: slow ignition ramp, one step per cycle
  assert_ign_ramp_R3: assert property (@(posedge clk) disable iff (rst)
    (in_ign && !ign_done) |=> (ramp == $past(ramp) + 1'b1));

  // R5: burst ramp advances by the fast step and wraps
  assert_run_ramp_R5: assert property (@(posedge clk) disable iff (rst)
    in_run |=> (ramp == $past(ramp) + STEP_V));
endmodule

// File: rtl/bal_delay_timer.sv
module bal_delay_timer #(
  parameter int DLY_W   = 8,
  parameter int DLY_MAX = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_run,
  input  logic             in_fault,
  input  logic             sd_hi,
  input  logic             oc_hi,
  output logic [DLY_W-1:0] cnt,
  output logic             hit
);
  localparam logic [DLY_W-1:0] MAX_V  = DLY_W'(DLY_MAX);
  localparam logic [DLY_W-1:0] LAST_V = DLY_W'(DLY_MAX - 1);

  logic sd_q;
  logic stress;

  assign stress = sd_hi || oc_hi;
  assign hit    = in_run && stress && (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sd_q <= 1'b0;
    end else begin
      sd_q <= sd_hi;
      if (in_run) begin
        if (stress) begin
          if (cnt != MAX_V) cnt <= cnt + 1'b1;
        end else if (sd_q) begin
          cnt <= '0;
        end
      end else if (!in_fault) begin
        cnt <= '0;
      end
    end
  end

  // R8: count never passes the terminal value
  assert_dly_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= MAX_V);

  // R6: open-load release clears the shared count
  assert_sd_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (in_run && !stress && sd_q) |=> (cnt == '0));

  // R7: over-current release holds the count (duty stays regulated)
  assert_oc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (in_run && !stress && !sd_q) |=> $stable(cnt));

  // R8: count frozen while faulted
  assert_fault_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (in_fault && !in_run) |=> $stable(cnt));
endmodule

// File: rtl/bal_seq_fsm.sv
module bal_seq_fsm
  import ballast_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_hi,
  input  logic       vcc_lo,
  input  logic       en,
  input  logic       cs_ign,
  input  logic       sd_hi,
  input  logic       ign_done,
  input  logic       dly_hit,
  output bal_state_t state_q,
  output logic       ign_mode_o,
  output logic       run_mode_o,
  output logic       osc_en_o,
  output logic       burst_en_o,
  output logic       fault_o
);
  bal_state_t nxt;
  logic       supply_ok;

  assign supply_ok = vcc_lo && en;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_IDLE:  if (vcc_hi && en) nxt = ST_IGN;
      ST_IGN: begin
        if (!supply_ok)    nxt = ST_IDLE;
        else if (ign_done) nxt = cs_ign ? ST_RUN : ST_FAULT;
      end
      ST_RUN: begin
        if (!supply_ok)   nxt = ST_IDLE;
        else if (dly_hit) nxt = ST_FAULT;
      end
      ST_FAULT: if (!vcc_lo) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ign_mode_o <= 1'b0;
      run_mode_o <= 1'b0;
      osc_en_o   <= 1'b0;
      burst_en_o <= 1'b0;
      fault_o    <= 1'b0;
    end else begin
      state_q    <= nxt;
      ign_mode_o <= (nxt == ST_IGN);
      run_mode_o <= (nxt == ST_RUN);
      osc_en_o   <= (nxt == ST_IGN) || (nxt == ST_RUN);
      burst_en_o <= (nxt == ST_RUN) && !sd_hi;
      fault_o    <= (nxt == ST_FAULT);
    end
  end

  // R1: idle until both start conditions hold
  assert_idle_wait_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !(vcc_hi && en)) |=> (!osc_en_o && !fault_o));

  // R2: start enters ignition at high frequency
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && vcc_hi && en) |=> (ign_mode_o && osc_en_o && !run_mode_o));

  // R4: window end with lamp current goes to run
  assert_ign_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGN && ign_done && supply_ok && cs_ign) |=> run_mode_o);

  // R4: window end without lamp current latches fault
  assert_ign_fail_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGN && ign_done && supply_ok && !cs_ign) |=> fault_o);

  // R8: terminal delay count latches fault
  assert_dly_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && dly_hit && supply_ok) |=> (fault_o && !osc_en_o && !burst_en_o));

  // R9: fault holds while supply stays above lower level
  assert_fault_latch_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FAULT && vcc_lo) |=> fault_o);

  // R10: supply or enable loss wins over every other transition
  assert_drop_R10: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IGN || state_q == ST_RUN) && !supply_ok) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import ballast_seq_pkg::*;
#(
  parameter int RAMP_W   = 8,
  parameter int IGN_TOP  = 200,
  parameter int RUN_STEP = 30,
  parameter int DLY_W    = 8,
  parameter int DLY_MAX  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vcc_above_hi,
  input  logic              vcc_above_lo,
  input  logic              enable,
  input  logic              cs_ign_hi,
  input  logic              cs_oc_hi,
  input  logic              sd_open_hi,
  output logic              ign_mode,
  output logic              run_mode,
  output logic              osc_en,
  output logic              burst_en,
  output logic              fault,
  output logic [DLY_W-1:0]  dly_cnt,
  output logic [RAMP_W-1:0] ramp
);
  bal_state_t state;
  logic       ign_done;
  logic       dly_hit;
  logic       in_ign, in_run, in_fault;

  assign in_ign   = (state == ST_IGN);
  assign in_run   = (state == ST_RUN);
  assign in_fault = (state == ST_FAULT);

  bal_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .vcc_hi     (vcc_above_hi),
    .vcc_lo     (vcc_above_lo),
    .en         (enable),
    .cs_ign     (cs_ign_hi),
    .sd_hi      (sd_open_hi),
    .ign_done   (ign_done),
    .dly_hit    (dly_hit),
    .state_q    (state),
    .ign_mode_o (ign_mode),
    .run_mode_o (run_mode),
    .osc_en_o   (osc_en),
    .burst_en_o (burst_en),
    .fault_o    (fault)
  );

  bal_ramp_gen #(
    .RAMP_W   (RAMP_W),
    .IGN_TOP  (IGN_TOP),
    .RUN_STEP (RUN_STEP)
  ) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .in_ign   (in_ign),
    .in_run   (in_run),
    .ramp     (ramp),
    .ign_done (ign_done)
  );

  bal_delay_timer #(
    .DLY_W   (DLY_W),
    .DLY_MAX (DLY_MAX)
  ) u_dly (
    .clk      (clk),
    .rst      (rst),
    .in_run   (in_run),
    .in_fault (in_fault),
    .sd_hi    (sd_open_hi),
    .oc_hi    (cs_oc_hi),
    .cnt      (dly_cnt),
    .hit      (dly_hit)
  );

  // R2: ignition and run are never selected together
  assert_mode_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ign_mode, run_mode, fault}));
endmodule

// File: tb/ballast_seq_bench.sv
module ballast_seq_bench;
  localparam int RAMP_W   = 8;
  localparam int IGN_TOP  = 200;
  localparam int RUN_STEP = 30;
  localparam int DLY_W    = 8;
  localparam int DLY_MAX  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rise = 1'b0, fall = 1'b0, en = 1'b0, csi = 1'b0, oc = 1'b0, sd = 1'b0;
  logic ign_mode, run_mode, osc_en, burst_en, fault;
  logic [DLY_W-1:0]  dly_cnt;
  logic [RAMP_W-1:0] ramp;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ballast_seq #(
    .RAMP_W(RAMP_W), .IGN_TOP(IGN_TOP), .RUN_STEP(RUN_STEP),
    .DLY_W(DLY_W), .DLY_MAX(DLY_MAX)
  ) u_ballast_seq (
    .clk(clk), .rst(rst), .vcc_above_hi(rise), .vcc_above_lo(fall),
    .enable(en), .cs_ign_hi(csi), .cs_oc_hi(oc), .sd_open_hi(sd),
    .ign_mode(ign_mode), .run_mode(run_mode), .osc_en(osc_en),
    .burst_en(burst_en), .fault(fault), .dly_cnt(dly_cnt), .ramp(ramp)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int run_ramp(input int k);
    return (k * RUN_STEP) % (1 << RAMP_W);
  endfunction

  function automatic int next_dly(input int c, input bit s, input bit o, input bit sq);
    if (s || o) return (c < DLY_MAX) ? c + 1 : c;
    if (sq) return 0;
    return c;
  endfunction

  task automatic go_run();
    sd = 0; oc = 0; csi = 1; en = 1;
    rise = 0; fall = 0; step();
    rise = 1; fall = 1; step();
    repeat (IGN_TOP + 1) step();
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    int m_dly;
    bit m_sdq;
    bit exp_f;
    void'($urandom(32'd20240917));

    repeat (3) step();
    rst = 0;
    check("R1 osc_en after reset", osc_en, 0);
    check("R1 fault after reset", fault, 0);
    check("R1 dly after reset", dly_cnt, 0);
    check("R1 ramp after reset", ramp, 0);

    rise = 1; fall = 1; en = 0;
    repeat (3) step();
    check("R1 stays idle without enable", osc_en, 0);

    en = 1; csi = 0; step();
    check("R2 ignition mode", ign_mode, 1);
    check("R2 osc_en", osc_en, 1);
    check("R2 ramp start", ramp, 0);
    for (int k = 1; k <= IGN_TOP; k++) begin
      step();
      if (k == IGN_TOP / 2) check("R3 mid ramp", ramp, k);
    end
    check("R3 ramp at top", ramp, IGN_TOP);
    check("R3 still igniting", ign_mode, 1);
    csi = 1; step();
    check("R4 run after ignition", run_mode, 1);
    check("R4 ignition ends", ign_mode, 0);
    check("R4 ramp restart", ramp, 0);

    for (int k = 1; k <= 12; k++) begin
      step();
      check("R5 burst ramp", ramp, run_ramp(k));
    end
    check("R5 burst_en", burst_en, 1);

    sd = 1; repeat (5) step();
    check("R6 sd count", dly_cnt, 5);
    check("R5 burst off with sd", burst_en, 0);
    sd = 0; step();
    check("R6 sd clear", dly_cnt, 0);

    oc = 1; repeat (5) step();
    check("R7 oc count", dly_cnt, 5);
    oc = 0; repeat (3) step();
    check("R7 oc hold", dly_cnt, 5);

    sd = 1; oc = 1; repeat (3) step();
    check("R7 both senses single rate", dly_cnt, 8);
    sd = 0; step();
    check("R7 oc keeps counting after sd drop", dly_cnt, 9);
    sd = 1; step();
    sd = 0; oc = 0; step();
    check("R6 joint release clears", dly_cnt, 0);

    oc = 1; repeat (DLY_MAX) step();
    check("R8 fault at terminal", fault, 1);
    check("R8 osc off", osc_en, 0);
    check("R8 dly at max", dly_cnt, DLY_MAX);
    oc = 0; en = 0; step(); en = 1; step();
    check("R9 fault ignores enable", fault, 1);
    check("R8 dly frozen", dly_cnt, DLY_MAX);
    rise = 0; step();
    check("R9 fault ignores upper bit", fault, 1);
    fall = 0; step();
    check("R9 fault released", fault, 0);
    check("R9 idle after release", osc_en, 0);
    fall = 1; step();
    check("R9 no restart without upper bit", osc_en, 0);
    rise = 1; step();
    check("R9 restart", ign_mode, 1);

    csi = 0; repeat (IGN_TOP + 1) step();
    check("R4 ignition failure", fault, 1);
    check("R4 no run", run_mode, 0);

    rise = 0; fall = 0; step();
    rise = 1; fall = 1; step();
    repeat (IGN_TOP) step();
    csi = 1; fall = 0; rise = 0; step();
    check("R10 drop beats window end run", run_mode, 0);
    check("R10 drop beats window end fault", fault, 0);
    check("R10 idle", osc_en, 0);

    go_run();
    check("R4 run via helper", run_mode, 1);
    oc = 1; repeat (DLY_MAX - 1) step();
    check("R7 one below terminal", dly_cnt, DLY_MAX - 1);
    en = 0; step();
    check("R10 enable loss beats terminal", fault, 0);
    check("R10 enable loss idle", run_mode, 0);
    oc = 0; en = 1;

    go_run();
    m_dly = 0; m_sdq = 0;
    for (int i = 0; i < 3000; i++) begin
      sd = ($urandom_range(0, 99) < 8);
      oc = ($urandom_range(0, 99) < 12);
      exp_f = (sd || oc) && (m_dly == DLY_MAX - 1);
      c = next_dly(m_dly, sd, oc, m_sdq);
      m_sdq = sd;
      step();
      check("R6 R7 random dly", dly_cnt, c);
      check("R8 random fault", fault, exp_f);
      check("R5 random burst_en", burst_en, (!exp_f && !sd));
      m_dly = c;
      if (exp_f) begin
        go_run();
        m_dly = 0; m_sdq = 0;
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule